// File: doc/BRIEF.md
# Scaled Index Effective Address Generator

This block forms the offset of a memory operand from up to three terms: a base register value, an index register value multiplied by a power-of-two scale, and a displacement that arrives either as a sign-carrying byte or as a full 32-bit word. Each term has its own valid flag, so one datapath covers every operand form. These forms are a plain displacement, a register used as a pointer, base plus displacement, index plus displacement, scaled index, base plus index, and base plus scaled index, each with or without a displacement.

The caller presents register-file read values, the index register number, the scale code, the displacement with its width flag, and the segment base, all together with a one-cycle request strobe. One clock later the block presents the effective address, the linear address (segment base plus effective address) and a matching valid strobe. The stack-pointer register may not serve as an index. Naming it raises an error flag, and the index term is then left out of the sum. Outputs hold their last values between requests.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_vld`, `idx_err`, `ea` and `lin` are all zero.
- R2: `out_vld` is high on exactly the cycle after a cycle with `req` high, and low otherwise.
- R3: `ea` equals the sum of the terms whose valid flags were set at the request: `base_val` when `base_vld` is set, the scaled index when `idx_vld` is set, and the displacement when `disp_vld` is set. A term whose flag is clear contributes zero, whatever its value.
- R4: Scale code 0, 1, 2 and 3 multiplies the index by 1, 2, 4 and 8 respectively, as a left shift of the index value.
- R5: With `disp_wide` = 0, only `disp_val[7:0]` is used, sign-extended from bit 7; bits 31:8 have no effect. With `disp_wide` = 1, all 32 bits are used.
- R6: All additions and the index shift wrap modulo 2^32.
- R7: `lin` equals `seg_base` at the request plus `ea`, modulo 2^32.
- R8: When `idx_vld` is set and `idx_num` equals 4 (the stack pointer), `idx_err` is high with the result, and the index term is excluded from `ea`.
- R9: `idx_num` of 4 with `idx_vld` clear raises no error. Any other index number never raises an error.
- R10: On a cycle after one with `req` low, `ea`, `lin` and `idx_err` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per address |
| base_vld | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| idx_vld | input | 1 | Index term present |
| idx_val | input | 32 | Index register value |
| idx_num | input | 3 | Index register number; 4 is the stack pointer |
| scale | input | 2 | Scale code, factor 2^scale |
| disp_vld | input | 1 | Displacement present |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: 8-bit sign-extended |
| disp_val | input | 32 | Displacement value |
| seg_base | input | 32 | Segment base for the linear address |
| out_vld | output | 1 | Result valid, one cycle after `req` |
| ea | output | 32 | Effective address |
| lin | output | 32 | Linear address |
| idx_err | output | 1 | Stack pointer selected as index |

## Verification
The block has a single register stage, so a wrong term selection, a wrong shift amount or a lost sign extension shows in `ea` on the very cycle that `out_vld` rises. A wrong segment sum shows in `lin` on that same cycle. A stale or mistimed hold register shows as a change in `ea` or `lin` on the first idle cycle after a result. A mis-decoded stack-pointer check shows both in `idx_err` and as an index term wrongly present in or missing from `ea`, again on the result cycle.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW     = 32,
  parameter int RW     = 3,
  parameter int NDW    = 8,
  parameter int SC_W   = 2,
  parameter int SP_NUM = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            base_vld,
  input  logic [AW-1:0]   base_val,
  input  logic            idx_vld,
  input  logic [AW-1:0]   idx_val,
  input  logic [RW-1:0]   idx_num,
  input  logic [SC_W-1:0] scale,
  input  logic            disp_vld,
  input  logic            disp_wide,
  input  logic [AW-1:0]   disp_val,
  input  logic [AW-1:0]   seg_base,
  output logic            out_vld,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   lin,
  output logic            idx_err
);

  localparam logic [RW-1:0] SP_CODE = RW'(SP_NUM);
  localparam int            EXT_W   = AW - NDW;

  logic          idx_is_sp;
  logic          idx_use;
  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] disp_short;
  logic [AW-1:0] disp_term;
  logic [AW-1:0] ea_nxt;
  logic [AW-1:0] lin_nxt;

  assign idx_is_sp  = (idx_num == SP_CODE);
  assign idx_use    = idx_vld && !idx_is_sp;
  assign base_term  = base_vld ? base_val : '0;
  assign idx_term   = idx_use ? (idx_val << scale) : '0;
  assign disp_short = {{EXT_W{disp_val[NDW-1]}}, disp_val[NDW-1:0]};
  assign disp_term  = !disp_vld ? '0 : (disp_wide ? disp_val : disp_short);
  assign ea_nxt     = base_term + idx_term + disp_term;
  assign lin_nxt    = seg_base + ea_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      ea      <= '0;
      lin     <= '0;
      idx_err <= 1'b0;
    end else begin
      out_vld <= req;
      if (req) begin
        ea      <= ea_nxt;
        lin     <= lin_nxt;
        idx_err <= idx_vld && idx_is_sp;
      end
    end
  end

endmodule

module ea_gen_chk #(
  parameter int AW = 32,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          base_vld,
  input logic          idx_vld,
  input logic [RW-1:0] idx_num,
  input logic          disp_vld,
  input logic          disp_wide,
  input logic [AW-1:0] disp_val,
  input logic [AW-1:0] seg_base,
  input logic          out_vld,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] lin,
  input logic          idx_err
);

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> out_vld);

  assert_no_valid_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out_vld);

  assert_disp_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !base_vld && !idx_vld && disp_vld && disp_wide) |=> (ea == $past(disp_val)));

  assert_linear_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (lin - ea == $past(seg_base)));

  assert_err_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && idx_vld && idx_num == RW'(4)) |=> idx_err);

  assert_no_err_when_idle_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !idx_vld) |=> !idx_err);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(ea) && $stable(lin) && $stable(idx_err)));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .base_vld(base_vld), .idx_vld(idx_vld),
  .idx_num(idx_num), .disp_vld(disp_vld), .disp_wide(disp_wide), .disp_val(disp_val),
  .seg_base(seg_base), .out_vld(out_vld), .ea(ea), .lin(lin), .idx_err(idx_err)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;

  typedef struct packed {
    logic        bv;
    logic [31:0] b;
    logic        iv;
    logic [31:0] i;
    logic [2:0]  n;
    logic [1:0]  s;
    logic        dv;
    logic        dw;
    logic [31:0] d;
    logic [31:0] sg;
    logic [31:0] e;
    logic        er;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b1, 1'b1, 32'h0000_1000, 32'h0, 32'h0000_1000, 1'b0},
    '{1'b1, 32'h0000_2000, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0001_0000, 32'h0000_2000, 1'b0},
    '{1'b1, 32'h0000_0100, 1'b0, 32'h0, 3'd0, 2'd0, 1'b1, 1'b0, 32'h0000_0018, 32'h0, 32'h0000_0118, 1'b0},
    '{1'b1, 32'h0000_0100, 1'b0, 32'h0, 3'd0, 2'd0, 1'b1, 1'b0, 32'hABCD_00F0, 32'h0, 32'h0000_00F0, 1'b0},
    '{1'b0, 32'h0, 1'b1, 32'h0000_0010, 3'd6, 2'd0, 1'b1, 1'b1, 32'h0000_0500, 32'h0, 32'h0000_0510, 1'b0},
    '{1'b0, 32'h0, 1'b1, 32'h0000_0010, 3'd6, 2'd1, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_0020, 1'b0},
    '{1'b1, 32'h0000_1000, 1'b1, 32'h0000_0010, 3'd7, 2'd2, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1040, 1'b0},
    '{1'b1, 32'h0000_1000, 1'b1, 32'h0000_0010, 3'd1, 2'd3, 1'b1, 1'b1, 32'h0000_0080, 32'h0, 32'h0000_1100, 1'b0},
    '{1'b1, 32'hFFFF_FFF0, 1'b0, 32'h0, 3'd0, 2'd0, 1'b1, 1'b0, 32'h0000_0020, 32'hFFFF_FFFF, 32'h0000_0010, 1'b0},
    '{1'b1, 32'h0000_0005, 1'b1, 32'h8000_0000, 3'd2, 2'd1, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_0005, 1'b0},
    '{1'b1, 32'h0000_3000, 1'b1, 32'h0000_1234, 3'd4, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_3000, 1'b1},
    '{1'b1, 32'h0000_3000, 1'b0, 32'h0000_1234, 3'd4, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_3000, 1'b0},
    '{1'b0, 32'h1111_1111, 1'b0, 32'h2222_2222, 3'd0, 2'd3, 1'b0, 1'b1, 32'h3333_3333, 32'h0000_0400, 32'h0, 1'b0},
    '{1'b1, 32'h0000_0007, 1'b0, 32'h0, 3'd0, 2'd0, 1'b0, 1'b1, 32'h5555_5555, 32'h0, 32'h0000_0007, 1'b0},
    '{1'b0, 32'h0, 1'b1, 32'h0000_0003, 3'd0, 2'd2, 1'b1, 1'b0, 32'h0000_00FF, 32'h0, 32'h0000_000B, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        base_vld = 1'b0, idx_vld = 1'b0, disp_vld = 1'b0, disp_wide = 1'b0;
  logic [31:0] base_val = '0, idx_val = '0, disp_val = '0, seg_base = '0;
  logic [2:0]  idx_num = '0;
  logic [1:0]  scale = '0;
  logic        out_vld, idx_err;
  logic [31:0] ea, lin;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .base_vld(base_vld), .base_val(base_val),
    .idx_vld(idx_vld), .idx_val(idx_val), .idx_num(idx_num), .scale(scale),
    .disp_vld(disp_vld), .disp_wide(disp_wide), .disp_val(disp_val),
    .seg_base(seg_base),
    .out_vld(out_vld), .ea(ea), .lin(lin), .idx_err(idx_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    base_vld = v.bv; base_val = v.b; idx_vld = v.iv; idx_val = v.i;
    idx_num = v.n; scale = v.s; disp_vld = v.dv; disp_wide = v.dw;
    disp_val = v.d; seg_base = v.sg;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_vld", {31'b0, out_vld}, 32'h0);
    chk("R1 ea", ea, 32'h0);
    chk("R1 lin", lin, 32'h0);
    chk("R1 idx_err", {31'b0, idx_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_vld after release", {31'b0, out_vld}, 32'h0);

    // R3 R4 R5 R6 R7 R8 R9: vector table
    for (int k = 0; k < NV; k++) begin
      load(VECS[k]);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk($sformatf("R2 vec%0d out_vld", k), {31'b0, out_vld}, 32'h1);
      chk($sformatf("R3 vec%0d ea", k), ea, VECS[k].e);
      chk($sformatf("R7 vec%0d lin", k), lin, VECS[k].sg + VECS[k].e);
      chk($sformatf("R8 vec%0d idx_err", k), {31'b0, idx_err}, {31'b0, VECS[k].er});
      // R10: idle cycle with disturbed inputs holds results
      base_val = 32'hDEAD_BEEF; seg_base = 32'h0BAD_0000; idx_vld = 1'b1; idx_num = 3'd4;
      @(negedge clk);
      chk($sformatf("R2 vec%0d idle out_vld", k), {31'b0, out_vld}, 32'h0);
      chk($sformatf("R10 vec%0d hold ea", k), ea, VECS[k].e);
      chk($sformatf("R10 vec%0d hold lin", k), lin, VECS[k].sg + VECS[k].e);
      chk($sformatf("R10 vec%0d hold err", k), {31'b0, idx_err}, {31'b0, VECS[k].er});
    end

    // R2: back-to-back requests, each result on its own cycle
    load(VECS[7]); req = 1'b1;
    @(negedge clk);
    load(VECS[10]);
    chk("R2 b2b first ea", ea, 32'h0000_1100);
    chk("R2 b2b first err", {31'b0, idx_err}, 32'h0);
    @(negedge clk);
    req = 1'b0;
    chk("R2 b2b second valid", {31'b0, out_vld}, 32'h1);
    chk("R8 b2b second ea", ea, 32'h0000_3000);
    chk("R8 b2b second err", {31'b0, idx_err}, 32'h1);
    @(negedge clk);
    chk("R2 b2b idle", {31'b0, out_vld}, 32'h0);

    // R5: narrow displacement 0x80 gives -128
    load('{1'b1, 32'h0000_0000, 1'b0, 32'h0, 3'd0, 2'd0, 1'b1, 1'b0, 32'h0000_0080, 32'h0, 32'h0, 1'b0});
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R5 narrow -128", ea, 32'hFFFF_FF80);

    // R6: wide sum wraps around zero
    load('{1'b1, 32'h8000_0000, 1'b1, 32'h4000_0000, 3'd3, 2'd1, 1'b1, 1'b1, 32'h0000_0001, 32'h8000_0000, 32'h0, 1'b0});
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R6 wrap ea", ea, 32'h0000_0001);
    chk("R6 wrap lin", lin, 32'h8000_0001);

    // R1: reset in mid-run clears results
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset ea", ea, 32'h0);
    chk("R1 re-reset lin", lin, 32'h0);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule